// File: doc/BRIEF.md
# Address-Triggered Memory Access Unit

This unit moves data between a CPU register file and interleaved main memory without any load or store opcode. The register file holds eight address/data pairs. Loading an address into pair 1 to 5 starts a read, and the word is delivered into the data half of the same pair. Loading an address into pair 6 or 7 starts a write of that pair's data half. Pair 0 only holds the address and touches no memory.

Memory is split into banks, selected by the low address bits. Each bank is occupied for a fixed number of cycles after it takes a request. A pending bit per data register tracks loads that are still in flight. Every read return carries the number of its destination register, so returns can be routed no matter what order they come back in. A peripheral port shares the banks and always wins over the CPU. The CPU is held back only by a pending register, by a busy bank, or by a peripheral request.

Top module: `lsu_areg`

## Requirements
- R1: After reset all address and data registers read 0, no pending bit is set, stall_o is low and wr_ready_o is high.
- R2: When an address write to index 1..5 is accepted, pend_o bit idx is set after that edge. The word at the address is written into data register idx on the third clock edge after acceptance, and the pending bit clears on that same edge.
- R3: When an address write to index 6 or 7 is accepted, the memory word at that address takes the value the data register of the same index held before that cycle. A data write in the same cycle does not change the stored value.
- R4: An address write to index 0 is always accepted. It stores the address, sets no pending bit and occupies no bank. Pending bits 0, 6 and 7 are never set.
- R5: An address write whose index has its pending bit set is refused (wr_ready_o low), and the address is not stored. A data write (xw) to a pending register is refused (xw_ready_o low), and its data is discarded.
- R6: The bank is address bits [2:0]. A bank takes a new request no earlier than 4 cycles after its last acceptance, and a CPU request to a busy bank is refused. Requests to different banks may be accepted on consecutive cycles. At most one bank accepts per cycle.
- R7: While pp_req_i is high, no CPU memory access (index 1..7) is accepted. pp_gnt_o is high exactly when the peripheral's bank is idle. A granted peripheral write updates memory.
- R8: A granted peripheral read raises pp_rvalid_o for one cycle, starting after the second clock edge that follows the grant edge, with the addressed word on pp_rdata_o.
- R9: Each read return writes only the data register named by its tag. Several loads to different banks in flight complete into their own registers. Stores and peripheral accesses leave the data registers unchanged.
- R10: stall_o is high exactly when a presented address write or data write is refused.
- R11: An accepted data write (xw) updates the data register on the next edge. rd_data_o and rd_addr_o show register rd_idx_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Address register write request |
| wr_idx_i | input | 3 | Address register index |
| wr_addr_i | input | AW | Address value |
| wr_ready_o | output | 1 | Address write accepted this cycle |
| xw_valid_i | input | 1 | Data register write request |
| xw_idx_i | input | 3 | Data register index |
| xw_data_i | input | DW | Data value |
| xw_ready_o | output | 1 | Data write accepted this cycle |
| rd_idx_i | input | 3 | Read port index |
| rd_addr_o | output | AW | Address register at rd_idx_i |
| rd_data_o | output | DW | Data register at rd_idx_i |
| pend_o | output | 8 | Pending-load bit per data register |
| stall_o | output | 1 | Some presented request was refused |
| pp_req_i | input | 1 | Peripheral memory request |
| pp_we_i | input | 1 | Peripheral write when high |
| pp_addr_i | input | AW | Peripheral address |
| pp_wdata_i | input | DW | Peripheral write data |
| pp_gnt_o | output | 1 | Peripheral request accepted |
| pp_rvalid_o | output | 1 | Peripheral read data valid |
| pp_rdata_o | output | DW | Peripheral read data |

## Verification
A pending bit that is set wrongly or never clears shows on pend_o right after the edge. It also shows as a refused wr_ready_o the next time that index is used, while a bit that clears early lets the data register change one edge off from the third-edge slot. A bank timer that is off by one changes the number of refused retries to a busy bank. A tag that is misrouted puts a word into the wrong data register three edges after issue. A peripheral return that is late, lost or duplicated shows when it is compared with a timestamped queue of expected words.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned NREG = 8;
  localparam int unsigned IW   = 3;

  localparam logic [IW-1:0] LD_LO = IW'(1);
  localparam logic [IW-1:0] LD_HI = IW'(5);
  localparam logic [IW-1:0] ST_LO = IW'(6);

  typedef enum logic {SRC_CPU = 1'b0, SRC_PP = 1'b1} src_e;
  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_STORE} aop_e;

  function automatic aop_e decode_idx(logic [IW-1:0] idx);
    if (idx >= LD_LO && idx <= LD_HI) return OP_LOAD;
    if (idx >= ST_LO) return OP_STORE;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/lsu_bank.sv
module lsu_bank
  import lsu_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned RW  = 5,
  parameter int unsigned CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          we_i,
  input  logic [RW-1:0] row_i,
  input  logic [DW-1:0] wdata_i,
  input  src_e          src_i,
  input  logic [IW-1:0] tag_i,
  output logic          busy_o,
  output logic          ret_valid_o,
  output src_e          ret_src_o,
  output logic [IW-1:0] ret_tag_o,
  output logic [DW-1:0] ret_data_o
);
  localparam int unsigned ROWS = 1 << RW;
  localparam int unsigned CW   = $clog2(CYC);

  logic [DW-1:0] mem_q [ROWS];
  logic [CW-1:0] cnt_q;
  logic          rd_q;
  src_e          src_q;
  logic [IW-1:0] tag_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      src_q  <= SRC_CPU;
      tag_q  <= '0;
      data_q <= '0;
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else begin
      if (acc_i) begin
        cnt_q <= CW'(CYC - 1);
        rd_q  <= !we_i;
        src_q <= src_i;
        tag_q <= tag_i;
        if (we_i) mem_q[row_i] <= wdata_i;
        else      data_q       <= mem_q[row_i];
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) rd_q <= 1'b0;
      end
    end
  end

  // return slot is the last busy cycle: one return per bank accept
  assign busy_o      = (cnt_q != '0);
  assign ret_valid_o = rd_q && (cnt_q == CW'(1));
  assign ret_src_o   = src_q;
  assign ret_tag_o   = tag_q;
  assign ret_data_o  = data_q;
endmodule

// File: rtl/lsu_regs.sv
module lsu_regs
  import lsu_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            a_we_i,
  input  logic [IW-1:0]   a_idx_i,
  input  logic [AW-1:0]   a_addr_i,
  input  logic            ld_set_i,
  input  logic            x_we_i,
  input  logic [IW-1:0]   x_idx_i,
  input  logic [DW-1:0]   x_data_i,
  input  logic            ret_we_i,
  input  logic [IW-1:0]   ret_tag_i,
  input  logic [DW-1:0]   ret_data_i,
  input  logic [IW-1:0]   rd_idx_i,
  input  logic [IW-1:0]   st_idx_i,
  output logic [NREG-1:0] pend_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic [DW-1:0]   rd_data_o,
  output logic [DW-1:0]   st_data_o
);
  logic [NREG-1:0][AW-1:0] a_q;
  logic [NREG-1:0][DW-1:0] x_q;
  logic [NREG-1:0]         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      x_q    <= '0;
      pend_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (a_we_i && a_idx_i == IW'(r)) a_q[r] <= a_addr_i;
        // a pending register never takes an xw write, so the two never collide
        if (ret_we_i && ret_tag_i == IW'(r))  x_q[r] <= ret_data_i;
        else if (x_we_i && x_idx_i == IW'(r)) x_q[r] <= x_data_i;
        if (ld_set_i && a_idx_i == IW'(r))        pend_q[r] <= 1'b1;
        else if (ret_we_i && ret_tag_i == IW'(r)) pend_q[r] <= 1'b0;
      end
    end
  end

  assign pend_o    = pend_q;
  assign rd_addr_o = a_q[rd_idx_i];
  assign rd_data_o = x_q[rd_idx_i];
  assign st_data_o = x_q[st_idx_i];
endmodule

// File: rtl/lsu_arb.sv
module lsu_arb
  import lsu_pkg::*;
#(
  parameter int unsigned NBANK = 8,
  parameter int unsigned BW    = 3
) (
  input  logic             cpu_valid_i,
  input  aop_e             cpu_op_i,
  input  logic [IW-1:0]    cpu_idx_i,
  input  logic [BW-1:0]    cpu_bank_i,
  input  logic             pp_req_i,
  input  logic [BW-1:0]    pp_bank_i,
  input  logic [NBANK-1:0] bank_busy_i,
  input  logic [NREG-1:0]  pend_i,
  output logic             cpu_ready_o,
  output logic             cpu_go_o,
  output logic             pp_gnt_o,
  output logic [NBANK-1:0] bank_acc_o
);
  logic cpu_mem_ok;

  always_comb begin
    pp_gnt_o    = pp_req_i && !bank_busy_i[pp_bank_i];
    cpu_mem_ok  = !pp_req_i && !bank_busy_i[cpu_bank_i] && !pend_i[cpu_idx_i];
    cpu_ready_o = (cpu_op_i == OP_NONE) ? 1'b1 : cpu_mem_ok;
    cpu_go_o    = cpu_valid_i && (cpu_op_i != OP_NONE) && cpu_mem_ok;
    bank_acc_o  = '0;
    if (pp_gnt_o)      bank_acc_o[pp_bank_i]  = 1'b1;
    else if (cpu_go_o) bank_acc_o[cpu_bank_i] = 1'b1;
  end
endmodule

// File: rtl/lsu_areg.sv
module lsu_areg
  import lsu_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned NBANK = 8,
  parameter int unsigned CYC   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [IW-1:0]       wr_idx_i,
  input  logic [AW-1:0]       wr_addr_i,
  output logic                wr_ready_o,
  input  logic                xw_valid_i,
  input  logic [IW-1:0]       xw_idx_i,
  input  logic [DW-1:0]       xw_data_i,
  output logic                xw_ready_o,
  input  logic [IW-1:0]       rd_idx_i,
  output logic [AW-1:0]       rd_addr_o,
  output logic [DW-1:0]       rd_data_o,
  output logic [NREG-1:0]     pend_o,
  output logic                stall_o,
  input  logic                pp_req_i,
  input  logic                pp_we_i,
  input  logic [AW-1:0]       pp_addr_i,
  input  logic [DW-1:0]       pp_wdata_i,
  output logic                pp_gnt_o,
  output logic                pp_rvalid_o,
  output logic [DW-1:0]       pp_rdata_o
);
  localparam int unsigned BW = $clog2(NBANK);
  localparam int unsigned RW = AW - BW;

  aop_e                   cpu_op;
  logic                   cpu_go;
  logic [NBANK-1:0]       bank_acc;
  logic [NBANK-1:0]       bank_busy;
  logic [NBANK-1:0]       bank_rv;
  src_e                   bank_src [NBANK];
  logic [NBANK-1:0][IW-1:0] bank_tag;
  logic [NBANK-1:0][DW-1:0] bank_data;
  logic [DW-1:0]          st_data;

  logic          req_we;
  logic [RW-1:0] req_row;
  logic [DW-1:0] req_wdata;
  src_e          req_src;

  logic          ret_v;
  src_e          ret_src;
  logic [IW-1:0] ret_tag;
  logic [DW-1:0] ret_data;

  assign cpu_op = decode_idx(wr_idx_i);

  lsu_arb #(.NBANK(NBANK), .BW(BW)) u_arb (
    .cpu_valid_i (wr_valid_i),
    .cpu_op_i    (cpu_op),
    .cpu_idx_i   (wr_idx_i),
    .cpu_bank_i  (wr_addr_i[BW-1:0]),
    .pp_req_i    (pp_req_i),
    .pp_bank_i   (pp_addr_i[BW-1:0]),
    .bank_busy_i (bank_busy),
    .pend_i      (pend_o),
    .cpu_ready_o (wr_ready_o),
    .cpu_go_o    (cpu_go),
    .pp_gnt_o    (pp_gnt_o),
    .bank_acc_o  (bank_acc)
  );

  assign req_we    = pp_gnt_o ? pp_we_i : (cpu_op == OP_STORE);
  assign req_row   = pp_gnt_o ? pp_addr_i[AW-1:BW] : wr_addr_i[AW-1:BW];
  assign req_wdata = pp_gnt_o ? pp_wdata_i : st_data;
  assign req_src   = pp_gnt_o ? SRC_PP : SRC_CPU;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    lsu_bank #(.DW(DW), .RW(RW), .CYC(CYC)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .acc_i       (bank_acc[b]),
      .we_i        (req_we),
      .row_i       (req_row),
      .wdata_i     (req_wdata),
      .src_i       (req_src),
      .tag_i       (wr_idx_i),
      .busy_o      (bank_busy[b]),
      .ret_valid_o (bank_rv[b]),
      .ret_src_o   (bank_src[b]),
      .ret_tag_o   (bank_tag[b]),
      .ret_data_o  (bank_data[b])
    );
  end

  // accepts are one per cycle with fixed latency, so returns never overlap
  always_comb begin
    ret_v    = 1'b0;
    ret_src  = SRC_CPU;
    ret_tag  = '0;
    ret_data = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_rv[b]) begin
        ret_v    = 1'b1;
        ret_src  = bank_src[b];
        ret_tag  = bank_tag[b];
        ret_data = bank_data[b];
      end
    end
  end

  assign pp_rvalid_o = ret_v && (ret_src == SRC_PP);
  assign pp_rdata_o  = ret_data;
  assign xw_ready_o  = !pend_o[xw_idx_i];
  assign stall_o     = (wr_valid_i && !wr_ready_o) || (xw_valid_i && !xw_ready_o);

  lsu_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_we_i     (wr_valid_i && wr_ready_o),
    .a_idx_i    (wr_idx_i),
    .a_addr_i   (wr_addr_i),
    .ld_set_i   (cpu_go && (cpu_op == OP_LOAD)),
    .x_we_i     (xw_valid_i && xw_ready_o),
    .x_idx_i    (xw_idx_i),
    .x_data_i   (xw_data_i),
    .ret_we_i   (ret_v && (ret_src == SRC_CPU)),
    .ret_tag_i  (ret_tag),
    .ret_data_i (ret_data),
    .rd_idx_i   (rd_idx_i),
    .st_idx_i   (wr_idx_i),
    .pend_o     (pend_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_o  (rd_data_o),
    .st_data_o  (st_data)
  );
endmodule

// File: rtl/lsu_areg_chk.sv
module lsu_areg_chk #(
  parameter int unsigned NBANK = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic [2:0]       wr_idx_i,
  input logic             wr_ready_o,
  input logic             xw_valid_i,
  input logic [2:0]       xw_idx_i,
  input logic             xw_ready_o,
  input logic             pp_req_i,
  input logic [7:0]       pend_o,
  input logic [NBANK-1:0] bank_acc_i,
  input logic [NBANK-1:0] bank_ret_i
);
  a_r7_pp_locks_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pp_req_i && wr_valid_i && wr_idx_i != 3'd0) |-> !wr_ready_o);

  a_r5_pending_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && pend_o[wr_idx_i]) |-> !wr_ready_o);

  a_r5_pending_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xw_valid_i && pend_o[xw_idx_i]) |-> !xw_ready_o);

  a_r2_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && wr_idx_i >= 3'd1 && wr_idx_i <= 3'd5)
      |=> pend_o[$past(wr_idx_i)]);

  a_r4_no_pend_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o[0] && (pend_o[7:6] == 2'b00));

  a_r6_one_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_acc_i));

  a_r6_bank_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_acc_i != '0) |=> ((bank_acc_i & $past(bank_acc_i)) == '0));

  a_r9_one_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_ret_i));
endmodule

bind lsu_areg lsu_areg_chk #(.NBANK(NBANK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .wr_idx_i   (wr_idx_i),
  .wr_ready_o (wr_ready_o),
  .xw_valid_i (xw_valid_i),
  .xw_idx_i   (xw_idx_i),
  .xw_ready_o (xw_ready_o),
  .pp_req_i   (pp_req_i),
  .pend_o     (pend_o),
  .bank_acc_i (bank_acc),
  .bank_ret_i (bank_rv)
);

// File: tb/sim_lsu_areg.sv
module sim_lsu_areg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [7:0]  wr_addr_i = '0;
  logic        wr_ready_o;
  logic        xw_valid_i = 1'b0;
  logic [2:0]  xw_idx_i = '0;
  logic [15:0] xw_data_i = '0;
  logic        xw_ready_o;
  logic [2:0]  rd_idx_i = '0;
  logic [7:0]  rd_addr_o;
  logic [15:0] rd_data_o;
  logic [7:0]  pend_o;
  logic        stall_o;
  logic        pp_req_i = 1'b0;
  logic        pp_we_i = 1'b0;
  logic [7:0]  pp_addr_i = '0;
  logic [15:0] pp_wdata_i = '0;
  logic        pp_gnt_o;
  logic        pp_rvalid_o;
  logic [15:0] pp_rdata_o;

  lsu_areg u0 (.*);

  always #10 clk_i = ~clk_i;

  typedef struct { logic [15:0] data; int due; } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc_n = 0;

  always @(posedge clk_i) cyc_n++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic a_issue(input logic [2:0] idx, input logic [7:0] addr, output logic ok);
    wr_valid_i = 1'b1; wr_idx_i = idx; wr_addr_i = addr;
    #1 ok = wr_ready_o;
    step();
    wr_valid_i = 1'b0;
  endtask

  task automatic a_retry(input logic [2:0] idx, input logic [7:0] addr, output int tries);
    tries = 0;
    forever begin
      wr_valid_i = 1'b1; wr_idx_i = idx; wr_addr_i = addr;
      #1 tries++;
      if (wr_ready_o || tries > 50) begin step(); break; end
      chk("R10 stall on busy bank", 32'(stall_o), 32'd1);
      step();
    end
    wr_valid_i = 1'b0;
  endtask

  task automatic x_write(input logic [2:0] idx, input logic [15:0] d, output logic ok);
    xw_valid_i = 1'b1; xw_idx_i = idx; xw_data_i = d;
    #1 ok = xw_ready_o;
    step();
    xw_valid_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [15:0] d, output logic [7:0] a);
    rd_idx_i = idx;
    #1 d = rd_data_o;
    a = rd_addr_o;
  endtask

  // monitor: peripheral read returns against the expected queue
  always @(negedge clk_i) begin
    if (rst_ni && pp_rvalid_o) begin
      if (exp_q.size() == 0) chk("R8 unexpected pp return", 32'd1, 32'd0);
      else begin
        mon_e = exp_q.pop_front();
        chk("R8 pp read data", 32'(pp_rdata_o), 32'(mon_e.data));
        chk("R8 pp return cycle", 32'(cyc_n), 32'(mon_e.due));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ok, ok2, ok3;
    logic [15:0] d;
    logic [7:0]  a;
    int tries;

    idle(3);
    rst_ni = 1'b1;
    step();

    // R1 reset state
    chk("R1 pend after reset", 32'(pend_o), 32'h0);
    chk("R1 stall after reset", 32'(stall_o), 32'h0);
    wr_idx_i = 3'd1;
    #1 chk("R1 ready after reset", 32'(wr_ready_o), 32'h1);
    for (int i = 0; i < 8; i++) begin
      step();
      rd(3'(i), d, a);
      chk("R1 data reg reset", 32'(d), 32'h0);
      chk("R1 addr reg reset", 32'(a), 32'h0);
    end
    step();

    // R11 data writes
    x_write(3'd6, 16'hA5A5, ok); chk("R11 xw accepted", 32'(ok), 32'd1);
    x_write(3'd7, 16'h3C3C, ok);
    rd(3'd6, d, a); chk("R11 xw readback", 32'(d), 32'hA5A5);
    step();

    // R3 store, R2 load timing
    a_issue(3'd6, 8'h12, ok); chk("R3 store accepted", 32'(ok), 32'd1);
    rd(3'd6, d, a); chk("R3 store addr held", 32'(a), 32'h12);
    idle(4);
    a_issue(3'd1, 8'h12, ok); chk("R2 load accepted", 32'(ok), 32'd1);
    chk("R2 pend set", 32'(pend_o), 32'h02);
    step(); step();
    chk("R2 pend held before return", 32'(pend_o), 32'h02);
    rd(3'd1, d, a); chk("R2 data not yet written", 32'(d), 32'h0);
    step();
    chk("R2 pend cleared on return", 32'(pend_o), 32'h00);
    rd(3'd1, d, a); chk("R2 R3 loaded stored word", 32'(d), 32'hA5A5);
    step();

    // R5 scoreboard stall, R10
    a_issue(3'd7, 8'h21, ok);
    idle(4);
    a_issue(3'd2, 8'h21, ok); chk("R5 first load accepted", 32'(ok), 32'd1);
    wr_valid_i = 1'b1; wr_idx_i = 3'd2; wr_addr_i = 8'h33;
    xw_valid_i = 1'b1; xw_idx_i = 3'd2; xw_data_i = 16'h1111;
    #1 chk("R5 addr write to pending refused", 32'(wr_ready_o), 32'd0);
    chk("R5 data write to pending refused", 32'(xw_ready_o), 32'd0);
    chk("R10 stall on refusal", 32'(stall_o), 32'd1);
    step();
    wr_valid_i = 1'b0; xw_valid_i = 1'b0;
    step(); step();
    rd(3'd2, d, a);
    chk("R5 refused xw discarded", 32'(d), 32'h3C3C);
    chk("R5 refused address not stored", 32'(a), 32'h21);
    chk("R10 no stall when idle", 32'(stall_o), 32'd0);
    step();

    // R6 bank busy window
    a_issue(3'd3, 8'h04, ok);
    a_retry(3'd4, 8'h0C, tries);
    chk("R6 same bank accepted on 4th try", 32'(tries), 32'd4);
    idle(4);

    // R3 sample at issue, R6 back-to-back, R9 tags
    x_write(3'd6, 16'h1001, ok);
    a_issue(3'd6, 8'h10, ok);
    x_write(3'd6, 16'h2002, ok);
    a_issue(3'd6, 8'h11, ok); chk("R6 store other bank accepted", 32'(ok), 32'd1);
    x_write(3'd6, 16'h5005, ok);
    wr_valid_i = 1'b1; wr_idx_i = 3'd6; wr_addr_i = 8'h15;
    xw_valid_i = 1'b1; xw_idx_i = 3'd6; xw_data_i = 16'h7777;
    #1 chk("R3 store with same-cycle xw accepted", 32'(wr_ready_o), 32'd1);
    step();
    wr_valid_i = 1'b0; xw_valid_i = 1'b0;
    rd(3'd6, d, a); chk("R11 same-cycle xw landed", 32'(d), 32'h7777);
    idle(4);
    a_issue(3'd1, 8'h10, ok);
    a_issue(3'd2, 8'h11, ok2);
    a_issue(3'd3, 8'h15, ok3);
    chk("R6 back-to-back loads", 32'({ok, ok2, ok3}), 32'h7);
    chk("R2 three loads pending", 32'(pend_o), 32'h0E);
    idle(4);
    rd(3'd1, d, a); chk("R9 tag 1 data", 32'(d), 32'h1001);
    rd(3'd2, d, a); chk("R9 tag 2 data", 32'(d), 32'h2002);
    rd(3'd3, d, a); chk("R3 store used pre-cycle data", 32'(d), 32'h5005);
    step();

    // R4 index 0
    a_issue(3'd0, 8'h17, ok); chk("R4 index 0 accepted", 32'(ok), 32'd1);
    chk("R4 no pend for index 0", 32'(pend_o), 32'h0);
    a_issue(3'd1, 8'h17, ok); chk("R4 index 0 left bank idle", 32'(ok), 32'd1);
    rd(3'd0, d, a); chk("R4 index 0 address held", 32'(a), 32'h17);
    idle(4);

    // R7 priority, R8 returns
    for (int k = 0; k < 3; k++) begin
      pp_req_i = 1'b1; pp_we_i = 1'b0; pp_addr_i = 8'(8'h10 + k);
      wr_valid_i = 1'b1; wr_idx_i = 3'd1; wr_addr_i = 8'h33;
      #1 chk("R7 pp granted", 32'(pp_gnt_o), 32'd1);
      chk("R7 cpu held off", 32'(wr_ready_o), 32'd0);
      exp_q.push_back('{data: (k == 0) ? 16'h1001 : (k == 1) ? 16'h2002 : 16'hA5A5,
                        due: cyc_n + 3});
      step();
    end
    pp_req_i = 1'b0;
    #1 chk("R7 cpu released", 32'(wr_ready_o), 32'd1);
    step();
    wr_valid_i = 1'b0;
    idle(4);

    a_issue(3'd4, 8'h24, ok);
    pp_req_i = 1'b1; pp_we_i = 1'b0; pp_addr_i = 8'h2C;
    #1 chk("R7 pp refused on busy bank", 32'(pp_gnt_o), 32'd0);
    step();
    pp_req_i = 1'b0;
    idle(4);

    rd(3'd5, d, a);
    pp_req_i = 1'b1; pp_we_i = 1'b1; pp_addr_i = 8'h23; pp_wdata_i = 16'hBEEF;
    #1 chk("R7 pp write granted", 32'(pp_gnt_o), 32'd1);
    step();
    pp_req_i = 1'b0; pp_we_i = 1'b0;
    idle(4);
    rd(3'd5, d, a); chk("R9 pp write left data reg", 32'(d), 32'h0);
    step();
    a_issue(3'd5, 8'h23, ok);
    idle(3);
    rd(3'd5, d, a); chk("R7 pp write reached memory", 32'(d), 32'hBEEF);

    idle(6);
    chk("R8 all pp returns seen", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule